// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Trigger Detector

This block watches the synchronized levels of one port of general-purpose pins and turns trigger conditions into a latched pending flag per pin. Each pin has its own trigger kind: a steady high or low level, a rising transition, a falling transition, or any transition. Pending flags stay set until software clears them with a write-one-to-clear strobe. Each flag is masked by a per-pin enable, and the enabled flags are ORed into one registered interrupt line for the port.

The trigger kind is packed into one configuration word built from three lanes of `NPIN` bits. A pin's bit in the lowest lane gives the active sense. Its bit in the middle lane picks transition or level detection. Its bit in the top lane requests detection of both transitions. Transitions are found by comparing each pin's present sample with a registered copy taken on the previous clock.

Top module: `gpio_irq_detect`

## Requirements
- R1: For pin i, trig_cfg_i[i] is the sense (1 = high or rising), trig_cfg_i[NPIN+i] selects transition (1) or level (0) detection, and trig_cfg_i[2*NPIN+i] requests both transitions.
- R2: With sense=1, transition=1 and both=0, a 0-to-1 change between two consecutive samples of a pin sets its pending bit at the clock edge that samples the 1.
- R3: With sense=0, transition=1 and both=0, a 1-to-0 change sets the pending bit at the clock edge that samples the 0. A change in the other direction does not set it.
- R4: With transition=1 and both=1, a change in either direction sets the pending bit, whatever the sense bit holds.
- R5: With transition=0, the pending bit is set on every clock edge at which the pin level equals the sense bit. It therefore stays set through a clear while the active level remains.
- R6: A pending bit stays set until cleared. A 0 in clr_i has no effect on it.
- R7: A 1 in clr_i[i] clears pending bit i at that clock edge when no trigger for pin i is present at the same edge.
- R8: When a trigger and a clear for the same pin fall on the same clock edge, the trigger wins and the pending bit is set after that edge.
- R9: irq_o is a register that, after each clock edge, equals the OR over pins of (new pending bit AND irq_en_i sampled at that edge). A pending pin whose enable is 0 does not raise irq_o.
- R10: While rst_i is high, pend_o and irq_o are 0 at each clock edge, and the previous-level copy follows the pins, so no spurious transition is seen after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_lvl_i | input | NPIN | Synchronized pin levels |
| trig_cfg_i | input | 3*NPIN | Trigger configuration, three lanes of NPIN bits |
| irq_en_i | input | NPIN | Per-pin interrupt enable |
| clr_i | input | NPIN | Write-one-to-clear strobe for pending bits |
| pend_o | output | NPIN | Pending status bits |
| irq_o | output | 1 | Registered port interrupt, active high |

## Verification
A new trigger and a clear strobe can land on the same pin in the same cycle. This is the race that decides whether a transition arriving during interrupt service is lost. The bench provokes it with directed cases: a transition pin and a level pin each receive a clear in the exact cycle their trigger condition holds. Long random runs also drive clr_i heavily while the pins toggle. In every such cycle the pending bit must end up set, and a bench model computes the expected pending vector and interrupt from the configuration lanes, independent of the RTL.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_ANY   = 2'd3
  } trig_kind_e;

  function automatic trig_kind_e decode_kind(input logic sense, input logic edge_sel,
                                             input logic both);
    if (!edge_sel)  return TRIG_LEVEL;
    else if (both)  return TRIG_ANY;
    else if (sense) return TRIG_RISE;
    else            return TRIG_FALL;
  endfunction

endpackage

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NPIN-1:0]   lvl_i,
  input  logic [3*NPIN-1:0] cfg_i,
  output logic [NPIN-1:0]   hit_o
);

  localparam int LANE_EDGE = NPIN;
  localparam int LANE_BOTH = 2 * NPIN;

  logic [NPIN-1:0] prev_q;

  // Previous-level copy follows the pins in reset too (R10)
  always_ff @(posedge clk_i) begin
    prev_q <= lvl_i;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    trig_kind_e kind;
    logic       rise, fall;

    always_comb begin
      kind = decode_kind(cfg_i[g], cfg_i[LANE_EDGE + g], cfg_i[LANE_BOTH + g]);
      rise = lvl_i[g] & ~prev_q[g];
      fall = ~lvl_i[g] & prev_q[g];
      unique case (kind)
        TRIG_LEVEL: hit_o[g] = (lvl_i[g] == cfg_i[g]);
        TRIG_RISE:  hit_o[g] = rise;
        TRIG_FALL:  hit_o[g] = fall;
        TRIG_ANY:   hit_o[g] = rise | fall;
        default:    hit_o[g] = 1'b0;
      endcase
    end

    AST_ANY_EDGE_SENSE_FREE: assert property (@(posedge clk_i) disable iff (rst_i)
      (cfg_i[LANE_EDGE + g] && cfg_i[LANE_BOTH + g] && (lvl_i[g] != prev_q[g])) |-> hit_o[g]); // R4
    AST_NO_HIT_STEADY_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
      (cfg_i[LANE_EDGE + g] && (lvl_i[g] == prev_q[g])) |-> !hit_o[g]); // R2
  end

endmodule

// File: rtl/gpio_pend_reg.sv
module gpio_pend_reg #(
  parameter int NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NPIN-1:0] hit_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] pend_nxt_o,
  output logic [NPIN-1:0] pend_q_o
);

  // Trigger outranks clear in the same cycle
  always_comb pend_nxt_o = (pend_q_o & ~clr_i) | hit_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) pend_q_o <= '0;
    else       pend_q_o <= pend_nxt_o;
  end

  AST_HOLD_WITHOUT_CLR: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (($past(pend_q_o) & ~$past(clr_i) & ~pend_q_o) == '0)); // R6
  AST_HIT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (($past(hit_i) & ~pend_q_o) == '0)); // R8
  AST_SET_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> ((pend_q_o & ~$past(pend_q_o) & ~$past(hit_i)) == '0)); // R2
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (($past(clr_i) & ~$past(hit_i) & pend_q_o) == '0)); // R7

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NPIN-1:0]   pin_lvl_i,
  input  logic [3*NPIN-1:0] trig_cfg_i,
  input  logic [NPIN-1:0]   irq_en_i,
  input  logic [NPIN-1:0]   clr_i,
  output logic [NPIN-1:0]   pend_o,
  output logic              irq_o
);

  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] pend_nxt;

  gpio_trig_detect #(.NPIN(NPIN)) u_detect (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i (pin_lvl_i),
    .cfg_i (trig_cfg_i),
    .hit_o (hit)
  );

  gpio_pend_reg #(.NPIN(NPIN)) u_pend (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hit_i      (hit),
    .clr_i      (clr_i),
    .pend_nxt_o (pend_nxt),
    .pend_q_o   (pend_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_o <= 1'b0;
    else       irq_o <= |(pend_nxt & irq_en_i);
  end

  AST_IRQ_MATCHES_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (irq_o == |(pend_o & $past(irq_en_i)))); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(irq_en_i) == '0) |-> !irq_o); // R9
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!irq_o && (pend_o == '0))); // R10

endmodule

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  localparam int NPIN = 8;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst;
  logic [NPIN-1:0]   pin_lvl;
  logic [3*NPIN-1:0] trig_cfg;
  logic [NPIN-1:0]   irq_en;
  logic [NPIN-1:0]   clr;
  logic [NPIN-1:0]   pend_o;
  logic              irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NPIN-1:0] m_prev = '0;
  logic [NPIN-1:0] m_pend = '0;
  logic            m_irq  = 1'b0;

  gpio_irq_detect #(.NPIN(NPIN)) dut (
    .clk_i(clk), .rst_i(rst), .pin_lvl_i(pin_lvl), .trig_cfg_i(trig_cfg),
    .irq_en_i(irq_en), .clr_i(clr), .pend_o(pend_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected trigger per pin from the three configuration lanes (R1..R5)
  function automatic logic [NPIN-1:0] exp_hit(input logic [NPIN-1:0] lvl,
      input logic [NPIN-1:0] prev, input logic [3*NPIN-1:0] cfg);
    logic [NPIN-1:0] h;
    for (int i = 0; i < NPIN; i++) begin
      logic s, e, b;
      s = cfg[i]; e = cfg[NPIN+i]; b = cfg[2*NPIN+i];
      if (!e)     h[i] = (lvl[i] == s);
      else if (b) h[i] = (lvl[i] != prev[i]);
      else if (s) h[i] = lvl[i] & ~prev[i];
      else        h[i] = ~lvl[i] & prev[i];
    end
    return h;
  endfunction

  function automatic logic [3*NPIN-1:0] one_kind(input int pin, input logic [2:0] sbe);
    logic [3*NPIN-1:0] c = '0;
    c[pin] = sbe[0]; c[NPIN+pin] = sbe[1]; c[2*NPIN+pin] = sbe[2];
    return c;
  endfunction

  task automatic check(input string req, input logic [NPIN-1:0] act_p,
                       input logic [NPIN-1:0] exp_p, input logic act_i, input logic exp_i);
    checks++;
    if (act_p !== exp_p || act_i !== exp_i) begin
      errors++;
      $display("FAIL %s: pend=%h irq=%b expected pend=%h irq=%b", req, act_p, act_i, exp_p, exp_i);
    end
  endtask

  // Drive at negedge, clock, update model, compare shortly after the edge
  task automatic step(input logic [NPIN-1:0] lvl, input logic [3*NPIN-1:0] cfg,
                      input logic [NPIN-1:0] en, input logic [NPIN-1:0] c, input string req);
    logic [NPIN-1:0] h;
    @(negedge clk);
    pin_lvl = lvl; trig_cfg = cfg; irq_en = en; clr = c;
    @(posedge clk);
    h = exp_hit(lvl, m_prev, cfg);
    if (rst) begin
      m_pend = '0; m_irq = 1'b0;
    end else begin
      m_pend = (m_pend & ~c) | h;
      m_irq  = |(m_pend & en);
    end
    m_prev = lvl;
    #1;
    check(req, pend_o, m_pend, irq_o, m_irq);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; pin_lvl = '1; trig_cfg = '0; irq_en = '1; clr = '0;
    // R10: reset holds outputs low, level-low config would otherwise trigger
    step('1, '0, '1, '0, "R10 reset");
    step('0, '0, '1, '0, "R10 reset");
    step('1, {NPIN{3'b0}} | {{NPIN{1'b0}}, {NPIN{1'b1}}, {NPIN{1'b0}}}, '1, '0, "R10 reset");
    rst = 1'b0;
    // R10: previous copy tracked pins during reset: steady high, any-edge -> no set
    step('1, {3*NPIN{1'b1}}, '1, '0, "R10 no spurious edge");
    // R2 rising on pin 0
    step('0, one_kind(0, 3'b011), 8'h01, '0, "R2 rise setup");
    step(8'h01, one_kind(0, 3'b011), 8'h01, '0, "R2 rise");
    // R6: clear of zero keeps it; level changes do not matter
    step(8'h00, one_kind(0, 3'b011), 8'h01, 8'h00, "R6 hold");
    // R7: clear
    step(8'h00, one_kind(0, 3'b011), 8'h01, 8'h01, "R7 clear");
    // R3 falling on pin 1: rising does nothing, falling sets
    step(8'h02, one_kind(1, 3'b010), 8'h02, '0, "R3 rise ignored");
    step(8'h00, one_kind(1, 3'b010), 8'h02, '0, "R3 fall");
    // R4: both edges with sense 0 and 1 on pins 2 and 3
    step(8'h00, one_kind(2, 3'b110) | one_kind(3, 3'b111), 8'h0c, 8'h02, "R4 setup");
    step(8'h04, one_kind(2, 3'b110) | one_kind(3, 3'b111), 8'h0c, '0, "R4 rise");
    step(8'h0c, one_kind(2, 3'b110) | one_kind(3, 3'b111), 8'h0c, 8'h04, "R4 rise other");
    step(8'h08, one_kind(2, 3'b110) | one_kind(3, 3'b111), 8'h0c, 8'h0c, "R4 fall");
    // R9: enable 0 masks irq although pending
    step(8'h08, one_kind(2, 3'b110), 8'h00, '0, "R9 masked");
    step(8'h08, one_kind(2, 3'b110), 8'h04, '0, "R9 enabled");
    // R8: edge and clear together on pin 4
    step(8'h00, one_kind(4, 3'b011), 8'h10, 8'hff, "R8 setup");
    step(8'h10, one_kind(4, 3'b011), 8'h10, 8'h10, "R8 edge wins");
    // R5: level high on pin 5 survives clear while high, then clears when low
    step(8'h20, one_kind(5, 3'b001), 8'h20, 8'hff, "R5 level set");
    step(8'h20, one_kind(5, 3'b001), 8'h20, 8'h20, "R5 level reasserts");
    step(8'h00, one_kind(5, 3'b001), 8'h20, 8'h20, "R5 level released");
    // R5 level low on pin 6
    step(8'h00, one_kind(6, 3'b000) | {{2*NPIN{1'b0}}, 8'hbf}, 8'h40, '0, "R5 level low");
    // R1: random configurations, levels, enables, clears
    for (int n = 0; n < 3000; n++) begin
      logic [NPIN-1:0] c;
      c = (($urandom % 3) == 0) ? NPIN'($urandom) : '0;
      step(NPIN'($urandom), (3*NPIN)'($urandom), NPIN'($urandom), c, "R1 random");
    end
    // R10: reset again mid-run
    rst = 1'b1;
    step('1, '0, '1, '0, "R10 reset again");
    rst = 1'b0;
    step('1, '0, '1, '0, "R9 after reset");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule